// File: doc/BRIEF.md
# Occupancy-Limited Thread-Block Admitter

This block decides whether one more thread block may become resident on a single compute unit. Three budgets are tracked for the unit:

- register words, 65,536 of 32 bits;
- shared-memory bytes, 233,472, which is 228 KB;
- warp slots, 64 warps of 32 threads, so 2048 threads.

A request states three things:

- how many threads the block has;
- how many registers each thread needs;
- how many shared-memory bytes the block needs.

The block is admitted only when every remaining budget covers its demand. When it is admitted, its usage is subtracted and it receives a resident-slot number. That number is later used to retire the block and give its resources back.

Requests arrive on a valid/ready channel. While the request does not fit, `req_ready` stays low and the request is pending. The requester may keep `req_valid` high with the fields unchanged and wait for resources to come back. It may also drop `req_valid` to withdraw the request. A request that fits is taken on the first edge where valid and ready are both high. The grant result appears as a one-cycle `grant_valid` pulse. The result channel cannot be stalled. Retirement is a plain strobe carrying a slot number.

The admitter also reports how many warps are active, and occupancy as active warps over the maximum, in fixed point. It reports which budget stopped the latest request that was evaluated and did not fit.

Top module: `occ_admitter`

## Requirements
- R1: After reset, all three budgets are full and `active_warps` is 0. `occupancy` is 0, `limit_code` is 0 and `grant_valid` is low.
- R2: The block's warp demand is its thread count divided by 32, rounded up. Its register demand is warps × 32 × registers per thread. A grant raises `active_warps` by the block's warp demand.
- R3: The block accepts a legal request (`req_ready` high) exactly when each remaining budget is greater than or equal to its demand; an exact fit is granted. One cycle after the handshake, `grant_valid` pulses. `grant_slot` then carries the lowest-numbered free slot.
- R4: A legal request that does not fit keeps `req_ready` low. It allocates nothing and produces no grant. The request may be held or withdrawn.
- R5: `limit_code` is updated in the cycle after each legal request is evaluated. It is 1 when registers are short, 2 when shared memory is short and 3 when warp slots are short. When several budgets are short, registers win over shared memory, and shared memory wins over warps. After a grant the code is 0. An illegal request leaves it unchanged, and it holds between evaluations.
- R6: A retire strobe naming an occupied slot returns that block's warps, registers and shared memory. A retire strobe naming a free slot has no effect.
- R7: When a retire and a request occur in the same cycle, the retired resources and the retired slot are freed first. The request is then evaluated against the updated budgets.
- R8: A request with 0 threads or more than 1024 threads is accepted and discarded. `req_drop` pulses one cycle later. No resource changes and no grant is made.
- R9: `occupancy` equals `active_warps` × 256 / 64, so full occupancy reads 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request fits, or is illegal and will be discarded |
| req_threads | input | 12 | Threads in the block |
| req_regs_per_thread | input | 8 | Registers per thread |
| req_smem_bytes | input | 18 | Shared-memory bytes per block |
| grant_valid | output | 1 | One-cycle pulse: a block was admitted |
| grant_slot | output | 6 | Slot of the admitted block |
| req_drop | output | 1 | One-cycle pulse: an illegal request was discarded |
| retire_valid | input | 1 | Retire strobe |
| retire_slot | input | 6 | Slot being retired |
| limit_code | output | 2 | Budget that stopped the last evaluated request: 0 none, 1 registers, 2 shared memory, 3 warps |
| active_warps | output | 7 | Warps currently resident |
| occupancy | output | 9 | Active over maximum warps, scaled by 256 |

## Verification
The assertions assume that a requester holding a pending request keeps the thread count, register count and byte count stable. Withdrawal, by dropping `req_valid`, is the only other allowed move. They also assume that retire strobes name slots returned by earlier grants, or free slots, which the block ignores. The stimulus is driven one request at a time from a task. A pending request is always withdrawn, never edited in place. Retire strobes use slots the bench model has recorded as granted, except for one deliberate strobe to a slot known to be free.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    LIM_NONE  = 2'd0,
    LIM_REGS  = 2'd1,
    LIM_SMEM  = 2'd2,
    LIM_WARPS = 2'd3
  } limit_e;
endpackage

// File: rtl/occ_demand.sv
module occ_demand #(
  parameter int WARP_SIZE         = 32,
  parameter int MAX_BLOCK_THREADS = 1024,
  parameter int THR_W             = 12,
  parameter int RPT_W             = 8,
  parameter int WARP_W            = 7,
  parameter int DEM_W             = 18
) (
  input  logic [THR_W-1:0]  threads,
  input  logic [RPT_W-1:0]  rpt,
  output logic              legal,
  output logic [WARP_W-1:0] warps,
  output logic [DEM_W-1:0]  regs
);
  localparam int WS_SH = $clog2(WARP_SIZE);

  logic [THR_W:0] rounded;
  logic [THR_W:0] wq;

  always_comb begin
    rounded = {1'b0, threads} + (THR_W+1)'(WARP_SIZE - 1);
    wq      = rounded >> WS_SH;
    legal   = (threads != '0) && ({1'b0, threads} <= (THR_W+1)'(MAX_BLOCK_THREADS));
    warps   = legal ? WARP_W'(wq) : '0;
    regs    = DEM_W'(warps) * DEM_W'(WARP_SIZE) * DEM_W'(rpt);
  end
endmodule

// File: rtl/occ_budget.sv
module occ_budget
  import occ_pkg::*;
#(
  parameter int NUM_REGS   = 65536,
  parameter int SMEM_BYTES = 233472,
  parameter int MAX_WARPS  = 64,
  parameter int RF_W       = 17,
  parameter int SM_W       = 18,
  parameter int WARP_W     = 7,
  parameter int DEM_W      = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              give,
  input  logic [WARP_W-1:0] dem_warps,
  input  logic [DEM_W-1:0]  dem_regs,
  input  logic [SM_W-1:0]   dem_smem,
  input  logic [WARP_W-1:0] ret_warps,
  input  logic [RF_W-1:0]   ret_regs,
  input  logic [SM_W-1:0]   ret_smem,
  output logic              fit,
  output limit_e            short_code,
  output logic [WARP_W-1:0] warps_free
);
  localparam int CW = ((RF_W > DEM_W) ? RF_W : DEM_W) + 1;

  logic [RF_W-1:0]   regs_free;
  logic [SM_W-1:0]   smem_free;
  logic [WARP_W-1:0] warps_free_q;
  logic [CW-1:0]     eff_regs;
  logic [SM_W:0]     eff_smem;
  logic [WARP_W:0]   eff_warps;
  logic              regs_ok, smem_ok, warps_ok;

  // Retired resources are added back before the new demand is compared.
  always_comb begin
    eff_regs  = CW'(regs_free) + (give ? CW'(ret_regs) : '0);
    eff_smem  = (SM_W+1)'(smem_free) + (give ? (SM_W+1)'(ret_smem) : '0);
    eff_warps = (WARP_W+1)'(warps_free_q) + (give ? (WARP_W+1)'(ret_warps) : '0);
    regs_ok   = eff_regs  >= CW'(dem_regs);
    smem_ok   = eff_smem  >= (SM_W+1)'(dem_smem);
    warps_ok  = eff_warps >= (WARP_W+1)'(dem_warps);
    fit       = regs_ok && smem_ok && warps_ok;
    if (!regs_ok)       short_code = LIM_REGS;
    else if (!smem_ok)  short_code = LIM_SMEM;
    else if (!warps_ok) short_code = LIM_WARPS;
    else                short_code = LIM_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_free    <= RF_W'(NUM_REGS);
      smem_free    <= SM_W'(SMEM_BYTES);
      warps_free_q <= WARP_W'(MAX_WARPS);
    end else begin
      regs_free    <= RF_W'(eff_regs - (take ? CW'(dem_regs) : '0));
      smem_free    <= SM_W'(eff_smem - (take ? (SM_W+1)'(dem_smem) : '0));
      warps_free_q <= WARP_W'(eff_warps - (take ? (WARP_W+1)'(dem_warps) : '0));
    end
  end

  assign warps_free = warps_free_q;
endmodule

// File: rtl/occ_slot_table.sv
module occ_slot_table #(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = 6,
  parameter int WARP_W = 7,
  parameter int RF_W   = 17,
  parameter int SM_W   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [WARP_W-1:0] alloc_warps,
  input  logic [RF_W-1:0]   alloc_regs,
  input  logic [SM_W-1:0]   alloc_smem,
  input  logic              ret_en,
  input  logic [SLOT_W-1:0] ret_slot,
  output logic              ret_hit,
  output logic [WARP_W-1:0] ret_warps,
  output logic [RF_W-1:0]   ret_regs,
  output logic [SM_W-1:0]   ret_smem,
  output logic              free_found,
  output logic [SLOT_W-1:0] free_slot
);
  logic [SLOTS-1:0]  busy;
  logic [SLOTS-1:0]  avail;
  logic [WARP_W-1:0] w_arr [SLOTS];
  logic [RF_W-1:0]   r_arr [SLOTS];
  logic [SM_W-1:0]   s_arr [SLOTS];

  always_comb begin
    ret_hit   = ret_en && busy[ret_slot];
    ret_warps = ret_hit ? w_arr[ret_slot] : '0;
    ret_regs  = ret_hit ? r_arr[ret_slot] : '0;
    ret_smem  = ret_hit ? s_arr[ret_slot] : '0;
  end

  // A slot retiring this cycle is already available to the new request.
  always_comb begin
    avail      = ~busy;
    if (ret_hit) avail[ret_slot] = 1'b1;
    free_found = |avail;
    free_slot  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (avail[i]) free_slot = SLOT_W'(i);
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              busy_q;
    logic [WARP_W-1:0] w_q;
    logic [RF_W-1:0]   r_q;
    logic [SM_W-1:0]   s_q;
    logic              sel_alloc, sel_ret;

    assign sel_alloc = alloc && (free_slot == SLOT_W'(g));
    assign sel_ret   = ret_hit && (ret_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        w_q    <= '0;
        r_q    <= '0;
        s_q    <= '0;
      end else if (sel_alloc) begin
        busy_q <= 1'b1;
        w_q    <= alloc_warps;
        r_q    <= alloc_regs;
        s_q    <= alloc_smem;
      end else if (sel_ret) begin
        busy_q <= 1'b0;
      end
    end

    assign busy[g]  = busy_q;
    assign w_arr[g] = w_q;
    assign r_arr[g] = r_q;
    assign s_arr[g] = s_q;
  end
endmodule

// File: rtl/occ_admitter.sv
module occ_admitter
  import occ_pkg::*;
#(
  parameter int NUM_REGS          = 65536,
  parameter int SMEM_BYTES        = 233472,
  parameter int MAX_WARPS         = 64,
  parameter int WARP_SIZE         = 32,
  parameter int MAX_BLOCK_THREADS = 1024,
  parameter int RPT_W             = 8,
  parameter int OCC_FRAC          = 8,
  parameter int THR_W             = $clog2(MAX_BLOCK_THREADS) + 2,
  parameter int SM_W              = $clog2(SMEM_BYTES + 1),
  parameter int SLOT_W            = $clog2(MAX_WARPS),
  parameter int WARP_W            = $clog2(MAX_WARPS + 1),
  parameter int OCC_W             = OCC_FRAC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [THR_W-1:0]  req_threads,
  input  logic [RPT_W-1:0]  req_regs_per_thread,
  input  logic [SM_W-1:0]   req_smem_bytes,
  output logic              grant_valid,
  output logic [SLOT_W-1:0] grant_slot,
  output logic              req_drop,
  input  logic              retire_valid,
  input  logic [SLOT_W-1:0] retire_slot,
  output logic [1:0]        limit_code,
  output logic [WARP_W-1:0] active_warps,
  output logic [OCC_W-1:0]  occupancy
);
  localparam int SLOTS = MAX_WARPS;
  localparam int RF_W  = $clog2(NUM_REGS + 1);
  localparam int DEM_W = $clog2(MAX_BLOCK_THREADS * ((1 << RPT_W) - 1) + 1) + 1;
  localparam int SC_W  = WARP_W + OCC_FRAC;

  logic              legal, fit, slot_found, take, drop;
  logic [WARP_W-1:0] dem_warps, warps_free;
  logic [DEM_W-1:0]  dem_regs;
  logic              ret_hit;
  logic [WARP_W-1:0] ret_warps;
  logic [RF_W-1:0]   ret_regs;
  logic [SM_W-1:0]   ret_smem;
  logic [SLOT_W-1:0] free_slot;
  limit_e            short_code, limit_q;
  logic [SC_W-1:0]   scaled;

  occ_demand #(
    .WARP_SIZE(WARP_SIZE), .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS),
    .THR_W(THR_W), .RPT_W(RPT_W), .WARP_W(WARP_W), .DEM_W(DEM_W)
  ) u_demand (
    .threads(req_threads), .rpt(req_regs_per_thread),
    .legal(legal), .warps(dem_warps), .regs(dem_regs)
  );

  occ_slot_table #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .WARP_W(WARP_W), .RF_W(RF_W), .SM_W(SM_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc(take), .alloc_warps(dem_warps), .alloc_regs(RF_W'(dem_regs)),
    .alloc_smem(req_smem_bytes),
    .ret_en(retire_valid), .ret_slot(retire_slot),
    .ret_hit(ret_hit), .ret_warps(ret_warps), .ret_regs(ret_regs), .ret_smem(ret_smem),
    .free_found(slot_found), .free_slot(free_slot)
  );

  occ_budget #(
    .NUM_REGS(NUM_REGS), .SMEM_BYTES(SMEM_BYTES), .MAX_WARPS(MAX_WARPS),
    .RF_W(RF_W), .SM_W(SM_W), .WARP_W(WARP_W), .DEM_W(DEM_W)
  ) u_budget (
    .clk(clk), .rst_n(rst_n),
    .take(take), .give(ret_hit),
    .dem_warps(dem_warps), .dem_regs(dem_regs), .dem_smem(req_smem_bytes),
    .ret_warps(ret_warps), .ret_regs(ret_regs), .ret_smem(ret_smem),
    .fit(fit), .short_code(short_code), .warps_free(warps_free)
  );

  assign req_ready = !legal || (fit && slot_found);
  assign take      = req_valid && legal && fit && slot_found;
  assign drop      = req_valid && !legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_slot  <= '0;
      req_drop    <= 1'b0;
      limit_q     <= LIM_NONE;
    end else begin
      grant_valid <= take;
      req_drop    <= drop;
      if (take) begin
        grant_slot <= free_slot;
        limit_q    <= LIM_NONE;
      end else if (req_valid && legal) begin
        limit_q    <= short_code;
      end
    end
  end

  always_comb begin
    active_warps = WARP_W'(MAX_WARPS) - warps_free;
    scaled       = SC_W'(active_warps) << OCC_FRAC;
    occupancy    = OCC_W'(scaled / SC_W'(MAX_WARPS));
    limit_code   = limit_q;
  end
endmodule

// File: rtl/occ_admitter_chk.sv
module occ_admitter_chk #(
  parameter int MAX_WARPS         = 64,
  parameter int MAX_BLOCK_THREADS = 1024,
  parameter int OCC_FRAC          = 8,
  parameter int THR_W             = 12,
  parameter int RPT_W             = 8,
  parameter int SM_W              = 18,
  parameter int WARP_W            = 7,
  parameter int OCC_W             = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [THR_W-1:0]  req_threads,
  input logic [RPT_W-1:0]  req_regs_per_thread,
  input logic [SM_W-1:0]   req_smem_bytes,
  input logic              grant_valid,
  input logic              req_drop,
  input logic              retire_valid,
  input logic [1:0]        limit_code,
  input logic [WARP_W-1:0] active_warps,
  input logic [OCC_W-1:0]  occupancy
);
  logic legal_req;
  assign legal_req = (req_threads != '0) && (req_threads <= THR_W'(MAX_BLOCK_THREADS));

  // R3
  warp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_warps <= WARP_W'(MAX_WARPS));

  // R3
  handshake_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (grant_valid || req_drop));

  // R2
  grant_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && legal_req && !retire_valid |=> active_warps > $past(active_warps));

  // R4
  stall_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && !retire_valid |=> $stable(active_warps) && !grant_valid);

  // R5
  grant_clears_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> limit_code == 2'd0);

  // R8
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && req_drop));

  // R9
  occ_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_warps == '0) |-> (occupancy == '0)) and
    ((active_warps == WARP_W'(MAX_WARPS)) |-> (occupancy == OCC_W'(1 << OCC_FRAC))));

  // R4
  pending_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !req_valid ||
      ($stable(req_threads) && $stable(req_regs_per_thread) && $stable(req_smem_bytes)));
endmodule

bind occ_admitter occ_admitter_chk #(
  .MAX_WARPS(MAX_WARPS), .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS), .OCC_FRAC(OCC_FRAC),
  .THR_W(THR_W), .RPT_W(RPT_W), .SM_W(SM_W), .WARP_W(WARP_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .req_regs_per_thread(req_regs_per_thread),
  .req_smem_bytes(req_smem_bytes), .grant_valid(grant_valid), .req_drop(req_drop),
  .retire_valid(retire_valid), .limit_code(limit_code),
  .active_warps(active_warps), .occupancy(occupancy)
);

// File: tb/test_occ_admitter.sv
module test_occ_admitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_threads = '0;
  logic [7:0]  req_regs_per_thread = '0;
  logic [17:0] req_smem_bytes = '0;
  logic        grant_valid;
  logic [5:0]  grant_slot;
  logic        req_drop;
  logic        retire_valid = 1'b0;
  logic [5:0]  retire_slot = '0;
  logic [1:0]  limit_code;
  logic [6:0]  active_warps;
  logic [8:0]  occupancy;

  always #4 clk = ~clk;

  occ_admitter i_occ_admitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs_per_thread(req_regs_per_thread),
    .req_smem_bytes(req_smem_bytes), .grant_valid(grant_valid), .grant_slot(grant_slot),
    .req_drop(req_drop), .retire_valid(retire_valid), .retire_slot(retire_slot),
    .limit_code(limit_code), .active_warps(active_warps), .occupancy(occupancy)
  );

  int checks = 0;
  int errors = 0;
  int exp_slots[$];

  // Bench model of the unit, built from the requirements.
  int  m_regs = 65536, m_smem = 233472, m_warps = 64, m_code = 0;
  bit  m_busy[64];
  int  m_w[64], m_r[64], m_s[64];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Scoreboard monitor: every grant pulse must match the next expected slot.
  always @(negedge clk) begin
    if (rst_n && grant_valid) begin
      if (exp_slots.size() == 0) chk(1'b0, "R4 unexpected grant", grant_slot, -1);
      else begin
        int e;
        e = exp_slots.pop_front();
        chk(grant_slot == e, "R3 grant slot", grant_slot, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic step(input bit rq_en, input int thr, input int rpt, input int sm,
                      input bit rt_en, input int rslot, input string tag);
    bit legal, fits;
    int w, r, code, slot;
    @(negedge clk);
    req_valid           = rq_en;
    req_threads         = 12'(thr);
    req_regs_per_thread = 8'(rpt);
    req_smem_bytes      = 18'(sm);
    retire_valid        = rt_en;
    retire_slot         = 6'(rslot);
    // R7: retired resources come back before the request is judged.
    if (rt_en && m_busy[rslot]) begin
      m_busy[rslot] = 1'b0;
      m_warps += m_w[rslot]; m_regs += m_r[rslot]; m_smem += m_s[rslot];
    end
    legal = (thr != 0) && (thr <= 1024);
    w = (thr + 31) / 32;
    r = w * 32 * rpt;
    fits = (r <= m_regs) && (sm <= m_smem) && (w <= m_warps);
    if (r > m_regs) code = 1;
    else if (sm > m_smem) code = 2;
    else if (w > m_warps) code = 3;
    else code = 0;
    #1;
    if (rq_en) chk(req_ready == (!legal || fits), {tag, " ready"}, req_ready, !legal || fits);
    if (rq_en && legal && fits) begin
      slot = 0;
      for (int i = 63; i >= 0; i--) if (!m_busy[i]) slot = i;
      exp_slots.push_back(slot);
      m_busy[slot] = 1'b1;
      m_w[slot] = w; m_r[slot] = r; m_s[slot] = sm;
      m_warps -= w; m_regs -= r; m_smem -= sm;
    end
    if (rq_en && legal) m_code = fits ? 0 : code;
    @(negedge clk);
    req_valid    = 1'b0;
    retire_valid = 1'b0;
    if (rq_en) chk(req_drop == (rq_en && !legal), {tag, " drop pulse R8"}, req_drop, !legal);
    chk(limit_code == 2'(m_code), {tag, " limit code R5"}, limit_code, m_code);
    chk(active_warps == 7'(64 - m_warps), {tag, " active warps R2"}, active_warps, 64 - m_warps);
    chk(occupancy == 9'((64 - m_warps) * 256 / 64), {tag, " occupancy R9"},
        occupancy, (64 - m_warps) * 256 / 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(active_warps == 0, "R1 reset active warps", active_warps, 0);
    chk(occupancy == 0, "R1 reset occupancy", occupancy, 0);
    chk(limit_code == 0, "R1 reset limit code", limit_code, 0);
    chk(grant_valid == 0, "R1 reset grant", grant_valid, 0);

    step(1, 256, 32, 16384, 0, 0, "R2 first block");
    step(1, 1024, 64, 0, 0, 0, "R4 registers short");
    step(1, 32, 1, 233472, 0, 0, "R4 smem short");
    step(1, 1024, 8, 0, 0, 0, "R3 second block");
    step(1, 1024, 8, 0, 0, 0, "R5 warps short");
    step(1, 1024, 64, 0, 0, 0, "R5 regs beats warps");
    chk(limit_code == 1, "R5 priority literal", limit_code, 1);
    step(1, 1025, 1, 0, 0, 0, "R8 oversize");
    step(1, 0, 1, 0, 0, 0, "R8 zero threads");
    step(0, 0, 0, 0, 1, 5, "R6 retire free slot");
    step(1, 1024, 8, 0, 1, 1, "R7 retire with request");
    step(0, 0, 0, 0, 1, 0, "R6 retire slot0");
    step(0, 0, 0, 0, 1, 1, "R6 retire slot1");
    chk(active_warps == 0, "R6 all returned", active_warps, 0);
    step(1, 1024, 64, 233472, 0, 0, "R3 exact fit");
    step(1, 1024, 0, 0, 0, 0, "R9 fill warps");
    chk(occupancy == 256, "R9 full occupancy literal", occupancy, 256);
    step(1, 32, 0, 0, 0, 0, "R5 no warps left");
    step(1, 33, 16, 100, 1, 0, "R7 R2 reuse slot0");
    chk(active_warps == 34, "R2 ceil warps literal", active_warps, 34);
    repeat (2) @(negedge clk);
    chk(exp_slots.size() == 0, "R3 all grants seen", exp_slots.size(), 0);
    finish_run();
  end
endmodule